// File: doc/BRIEF.md
# Register-Mapped Multiply/Divide Unit

This block is an arithmetic peripheral that a processor drives through a byte-wide address/data/strobe port. Software loads operand bytes and then writes the high byte of the second operand. That final write starts the operation. A write to the multiplier's high byte forms a 16x16 product in the same clock. A write to the divisor's high byte starts a 32/16 divide that runs for 32 clocks. Results are read back one byte at a time. A single status bit reports completion and clears itself when it is read.

A control byte selects unsigned or two's-complement arithmetic. Writing that byte also wipes every operand and result register, which gives software a clean starting point. Division by zero does not trap: it returns a fixed, defined result.

Top module: `mdu_top`

## Requirements
- R1: After reset, every readable offset (0 to 15) returns 0x00.
- R2: With control bit 0 clear, a write to offset 5 (multiplier high byte; offset 4 is the low byte) forms the unsigned product of the multiplier and dividend bytes 0..1. The product appears at offsets 8..11, least significant byte first, and the status flag is set by the next clock edge.
- R3: With control bit 0 set, the multiply of R2 treats both 16-bit operands as two's complement and gives the 32-bit signed product.
- R4: A write to offset 7 (divisor high byte; offset 6 is the low byte) starts a divide of the 32-bit dividend at offsets 0..3 (least significant first). The start clears the status flag. The quotient appears at offsets 8..11 and the remainder at offsets 12..13 exactly 32 clock edges after the start edge. The flag reads 0 until then.
- R5: With control bit 0 set, the divide is signed. The quotient truncates toward zero, and the remainder carries the sign of the dividend.
- R6: When the divisor is zero, the quotient is 0 and the remainder equals the low 16 bits of the dividend. The operation still completes after 32 edges.
- R7: Reading offset 15 returns 0x80 while the flag is set (bit 7; other bits read 0) and clears the flag. The next read returns 0x00.
- R8: A write to offset 14 stores the control byte, which reads back unchanged. It zeroes all operand, result and remainder registers, cancels a divide in progress so that it never completes, and leaves the status flag unchanged.
- R9: When a status read falls in the same cycle as a divide completing, the read returns 0x00, the flag ends set, and the following read returns 0x80.
- R10: Operand bytes at offsets 0..7 read back the last value written to them.
- R11: Writes to offsets 8..13 and 15 have no effect on any register or on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; only side effect is clearing the flag at offset 15 |
| addr | input | ADDR_W (4) | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed offset, combinational |

## Verification
Completion of a divide and a status read can fall in the same cycle: the divider sets the flag while the read strobe tries to clear it. The bench provokes this by starting a divide and placing a status read exactly 31 cycles later, so that the read overlaps the final divide step. It judges the outcome by the value returned in that cycle, which must be 0x00, and by the next read, which must return 0x80. Around this case, multiplies and divides are swept over grids of boundary operands in both modes, with the expected values computed in 64-bit integer arithmetic in the bench.

// File: rtl/mdu_pkg.sv
// Shared constants and types for the multiply/divide unit.
package mdu_pkg;
    localparam int BYTE_W = 8;
    localparam logic [7:0] STATUS_DONE = 8'h80;

    typedef enum logic {
        MATH_UNSIGNED = 1'b0,
        MATH_SIGNED   = 1'b1
    } math_mode_e;
endpackage

// File: rtl/mdu_mult.sv
// Combinational OPW x OPW multiplier with a signed/unsigned selector.
// Assumes the caller registers the 2*OPW-bit product.
module mdu_mult #(
    parameter int OPW = 16
) (
    input  mdu_pkg::math_mode_e mode,
    input  logic [OPW-1:0]      op_a,
    input  logic [OPW-1:0]      op_b,
    output logic [2*OPW-1:0]    prod
);
    localparam int PW = 2 * OPW;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;

    // Sign- or zero-extend both operands, then keep the low PW bits of the product.
    always_comb begin
        if (mode == mdu_pkg::MATH_SIGNED) begin
            ext_a = {{OPW{op_a[OPW-1]}}, op_a};
            ext_b = {{OPW{op_b[OPW-1]}}, op_b};
        end else begin
            ext_a = {{OPW{1'b0}}, op_a};
            ext_b = {{OPW{1'b0}}, op_b};
        end
        prod = ext_a * ext_b;
    end
endmodule

// File: rtl/mdu_div.sv
// Iterative restoring divider: a 2*OPW-bit dividend over an OPW-bit divisor,
// one quotient bit per clock, 2*OPW steps after the start edge.
// Signed mode divides magnitudes and fixes signs on the final step.
// A zero divisor gives quotient 0 and the dividend's low OPW bits as remainder.
// Assumes start and abort are single-cycle strobes; abort wins over start.
module mdu_div #(
    parameter int OPW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                abort,
    input  mdu_pkg::math_mode_e mode,
    input  logic [2*OPW-1:0]    dividend,
    input  logic [OPW-1:0]      divisor,
    output logic                busy,
    output logic                done,
    output logic [2*OPW-1:0]    quot,
    output logic [OPW-1:0]      rem
);
    localparam int DW    = 2 * OPW;
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DW - 1);

    logic             busy_q;
    logic [CNT_W-1:0] step_q;
    logic [DW-1:0]    quo_q;
    logic [OPW-1:0]   acc_q;
    logic [OPW-1:0]   dvs_q;
    logic             negq_q;
    logic             negr_q;
    logic             zero_q;
    logic [OPW-1:0]   zlow_q;

    logic           dvd_neg;
    logic           dvs_neg;
    logic [DW-1:0]  dvd_mag;
    logic [OPW-1:0] dvs_mag;
    logic [OPW:0]   shifted;
    logic           take;
    logic [OPW-1:0] acc_nx;
    logic [DW-1:0]  quo_nx;
    logic [DW-1:0]  q_fix;
    logic [OPW-1:0] r_fix;

    // Operand magnitudes and sign flags captured at start.
    always_comb begin
        dvd_neg = (mode == mdu_pkg::MATH_SIGNED) && dividend[DW-1];
        dvs_neg = (mode == mdu_pkg::MATH_SIGNED) && divisor[OPW-1];
        dvd_mag = dvd_neg ? (DW'(0) - dividend) : dividend;
        dvs_mag = dvs_neg ? (OPW'(0) - divisor) : divisor;
    end

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        shifted = {acc_q, quo_q[DW-1]};
        take    = (shifted >= {1'b0, dvs_q});
        acc_nx  = take ? OPW'(shifted - {1'b0, dvs_q}) : shifted[OPW-1:0];
        quo_nx  = {quo_q[DW-2:0], take};
    end

    // Sign correction and divide-by-zero substitution on the final step's values.
    always_comb begin
        q_fix = negq_q ? (DW'(0) - quo_nx) : quo_nx;
        r_fix = negr_q ? (OPW'(0) - acc_nx) : acc_nx;
        quot  = zero_q ? '0 : q_fix;
        rem   = zero_q ? zlow_q : r_fix;
    end

    assign busy = busy_q;
    assign done = busy_q && (step_q == LAST_STEP) && !start && !abort;

    // Sequencer: load on start, one step per cycle, stop on the last step or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= '0;
            quo_q  <= '0;
            acc_q  <= '0;
            dvs_q  <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            zero_q <= 1'b0;
            zlow_q <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            step_q <= '0;
            quo_q  <= dvd_mag;
            acc_q  <= '0;
            dvs_q  <= dvs_mag;
            negq_q <= dvd_neg ^ dvs_neg;
            negr_q <= dvd_neg;
            zero_q <= (divisor == '0);
            zlow_q <= dividend[OPW-1:0];
        end else if (busy_q) begin
            quo_q  <= quo_nx;
            acc_q  <= acc_nx;
            step_q <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
                busy_q <= 1'b0;
            end
        end
    end

    // R4: an accepted start begins a fresh run from step zero.
    a_r4_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (busy && step_q == '0));

    // R8: a cancel leaves the divider idle.
    a_r8_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);
endmodule

// File: rtl/mdu_flag.sv
// Completion flag: a set wins over clears raised in the same cycle.
// Assumes set and the clear requests are single-cycle strobes.
module mdu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr_start,
    input  logic clr_read,
    output logic flag
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr_start || clr_read) begin
            flag <= 1'b0;
        end
    end

    // R7: a status read without a concurrent completion clears the flag.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_read && !set) |=> !flag);

    // R9: completion is never lost to a concurrent clear.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/mdu_top.sv
// Register-mapped multiply/divide unit with a byte-wide bus port.
// Offsets are derived from OPW: dividend, multiplier, divisor, result,
// remainder, control, status. With OPW=16 these are 0-3, 4-5, 6-7, 8-11,
// 12-13, 14 and 15.
// Assumes OPW is a multiple of 8 and at least 16, at most one write per cycle,
// and ADDR_W wide enough for every offset.
module mdu_top #(
    parameter int OPW    = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    import mdu_pkg::*;

    localparam int DW        = 2 * OPW;
    localparam int DVD_BYTES = DW / BYTE_W;
    localparam int OP_BYTES  = OPW / BYTE_W;
    localparam int DVD_BASE  = 0;
    localparam int MLT_BASE  = DVD_BASE + DVD_BYTES;
    localparam int DVS_BASE  = MLT_BASE + OP_BYTES;
    localparam int RES_BASE  = DVS_BASE + OP_BYTES;
    localparam int REM_BASE  = RES_BASE + DVD_BYTES;
    localparam int CTRL_ADDR = REM_BASE + OP_BYTES;
    localparam int STAT_ADDR = CTRL_ADDR + 1;

    logic [DW-1:0]  dvd_q;
    logic [OPW-1:0] mlt_q;
    logic [OPW-1:0] dvs_q;
    logic [DW-1:0]  res_q;
    logic [OPW-1:0] rem_q;
    logic [7:0]     ctrl_q;

    logic [DVD_BYTES-1:0] dvd_we;
    logic [OP_BYTES-1:0]  mlt_we;
    logic [OP_BYTES-1:0]  dvs_we;
    logic ctrl_we;
    logic stat_rd;
    logic mul_go;
    logic div_go;
    logic div_busy;
    logic div_done;
    logic flag;
    math_mode_e     mode;
    logic [OPW-1:0] mul_b;
    logic [OPW-1:0] div_b;
    logic [DW-1:0]  prod;
    logic [DW-1:0]  dquot;
    logic [OPW-1:0] drem;

    // Per-byte write decode for the dividend lanes.
    for (genvar gi = 0; gi < DVD_BYTES; gi++) begin : g_dvd_we
        assign dvd_we[gi] = wr_en && (addr == ADDR_W'(DVD_BASE + gi));
    end

    // Per-byte write decode for the multiplier and divisor lanes.
    for (genvar gj = 0; gj < OP_BYTES; gj++) begin : g_op_we
        assign mlt_we[gj] = wr_en && (addr == ADDR_W'(MLT_BASE + gj));
        assign dvs_we[gj] = wr_en && (addr == ADDR_W'(DVS_BASE + gj));
    end

    assign ctrl_we = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    assign stat_rd = rd_en && (addr == ADDR_W'(STAT_ADDR));
    assign mul_go  = mlt_we[OP_BYTES-1];
    assign div_go  = dvs_we[OP_BYTES-1];
    assign mode    = math_mode_e'(ctrl_q[0]);

    // The triggering write supplies the top byte straight from the bus.
    assign mul_b = {wdata, mlt_q[OPW-BYTE_W-1:0]};
    assign div_b = {wdata, dvs_q[OPW-BYTE_W-1:0]};

    mdu_mult #(.OPW(OPW)) u_mult (
        .mode (mode),
        .op_a (dvd_q[OPW-1:0]),
        .op_b (mul_b),
        .prod (prod)
    );

    mdu_div #(.OPW(OPW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_go),
        .abort    (ctrl_we || mul_go),
        .mode     (mode),
        .dividend (dvd_q),
        .divisor  (div_b),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (dquot),
        .rem      (drem)
    );

    mdu_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (mul_go || div_done),
        .clr_start (div_go),
        .clr_read  (stat_rd),
        .flag      (flag)
    );

    // Control byte: holds the mode and reads back as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= wdata;
        end
    end

    // Operand bytes: written lane by lane, wiped by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_we) begin
            dvd_q <= '0;
            mlt_q <= '0;
            dvs_q <= '0;
        end else begin
            for (int i = 0; i < DVD_BYTES; i++) begin
                if (dvd_we[i]) dvd_q[i*BYTE_W +: BYTE_W] <= wdata;
            end
            for (int j = 0; j < OP_BYTES; j++) begin
                if (mlt_we[j]) mlt_q[j*BYTE_W +: BYTE_W] <= wdata;
                if (dvs_we[j]) dvs_q[j*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

    // Result and remainder: loaded by a multiply or a divide completion.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_we) begin
            res_q <= '0;
            rem_q <= '0;
        end else if (mul_go) begin
            res_q <= prod;
        end else if (div_done) begin
            res_q <= dquot;
            rem_q <= drem;
        end
    end

    // Read mux over every offset; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DVD_BYTES; i++) begin
            if (addr == ADDR_W'(DVD_BASE + i)) rdata = dvd_q[i*BYTE_W +: BYTE_W];
            if (addr == ADDR_W'(RES_BASE + i)) rdata = res_q[i*BYTE_W +: BYTE_W];
        end
        for (int j = 0; j < OP_BYTES; j++) begin
            if (addr == ADDR_W'(MLT_BASE + j)) rdata = mlt_q[j*BYTE_W +: BYTE_W];
            if (addr == ADDR_W'(DVS_BASE + j)) rdata = dvs_q[j*BYTE_W +: BYTE_W];
            if (addr == ADDR_W'(REM_BASE + j)) rdata = rem_q[j*BYTE_W +: BYTE_W];
        end
        if (addr == ADDR_W'(CTRL_ADDR)) rdata = ctrl_q;
        if (addr == ADDR_W'(STAT_ADDR)) rdata = flag ? STATUS_DONE : 8'h00;
    end

    // R8: a control write leaves every operand and result register at zero.
    a_r8_ctrl_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (dvd_q == '0 && mlt_q == '0 && dvs_q == '0 &&
                     res_q == '0 && rem_q == '0));

    // R2: a multiply sets the flag on the next edge and cancels any divide.
    a_r2_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |=> (flag && !div_busy));

    // R9: a divide completion is visible in the flag on the next cycle.
    a_r9_div_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |=> flag);
endmodule

// File: tb/mdu_top_test.sv
// Self-checking bench: sweeps multiply and divide over boundary operands,
// both modes, plus flag, clear and same-cycle cases.
module mdu_top_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic       rd_en;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [3:0] A_DVD = 4'd0, A_MLT = 4'd4, A_DVS = 4'd6, A_RES = 4'd8;
    localparam logic [3:0] A_REM = 4'd12, A_CTRL = 4'd14, A_STAT = 4'd15;

    always #5 clk = ~clk;

    mdu_top uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr32(input logic [3:0] base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(4'(base + i), v[i*8 +: 8]);
    endtask

    task automatic rd32(input logic [3:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(4'(base + i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic rd16(input logic [3:0] base, output logic [15:0] v);
        logic [7:0] b;
        for (int i = 0; i < 2; i++) begin
            rd(4'(base + i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic do_mul(input logic [15:0] a, input logic [15:0] b, input bit sgn);
        logic [31:0] got;
        logic [31:0] exp;
        logic [7:0]  s;
        longint      p;
        wr(A_DVD, a[7:0]); wr(A_DVD + 4'd1, a[15:8]);
        wr(A_MLT, b[7:0]); wr(A_MLT + 4'd1, b[15:8]);
        if (sgn) p = longint'($signed(a)) * longint'($signed(b));
        else     p = longint'(a) * longint'(b);
        exp = p[31:0];
        rd32(A_RES, got);
        check(sgn ? "R3 signed product" : "R2 unsigned product", got, exp);
        rd(A_STAT, s); check("R7 flag after multiply", {24'h0, s}, 32'h80);
        rd(A_STAT, s); check("R7 flag cleared by read", {24'h0, s}, 32'h0);
    endtask

    task automatic do_div(input logic [31:0] n, input logic [15:0] d, input bit sgn);
        logic [31:0] gq;
        logic [15:0] gr;
        logic [31:0] eq;
        logic [15:0] er;
        logic [7:0]  s;
        longint      ln;
        longint      ld;
        longint      lq;
        longint      lr;
        wr32(A_DVD, n);
        wr(A_DVS, d[7:0]); wr(A_DVS + 4'd1, d[15:8]);
        repeat (20) @(negedge clk);
        rd(A_STAT, s); check("R4 flag clear while dividing", {24'h0, s}, 32'h0);
        repeat (11) @(negedge clk);
        if (d == 16'h0) begin
            eq = 32'h0; er = n[15:0];
        end else begin
            ln = sgn ? longint'($signed(n)) : longint'(n);
            ld = sgn ? longint'($signed(d)) : longint'(d);
            lq = ln / ld; lr = ln % ld;
            eq = lq[31:0]; er = lr[15:0];
        end
        rd32(A_RES, gq);
        rd16(A_REM, gr);
        if (d == 16'h0) begin
            check("R6 zero divisor quotient", gq, eq);
            check("R6 zero divisor remainder", {16'h0, gr}, {16'h0, er});
        end else if (sgn) begin
            check("R5 signed quotient", gq, eq);
            check("R5 signed remainder", {16'h0, gr}, {16'h0, er});
        end else begin
            check("R4 unsigned quotient", gq, eq);
            check("R4 unsigned remainder", {16'h0, gr}, {16'h0, er});
        end
        rd(A_STAT, s); check("R4 flag after 32 cycles", {24'h0, s}, 32'h80);
    endtask

    localparam logic [15:0] MVALS [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
        16'h007F, 16'h0080, 16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
    localparam logic [31:0] NVALS [12] = '{32'h0, 32'h1, 32'h7, 32'd100, 32'h7FFFFFFF,
        32'h80000000, 32'hFFFFFFFF, 32'h12345678, 32'hFFFFFFF9, 32'h80000001,
        32'h0000FFFF, 32'hDEADBEEF};
    localparam logic [15:0] DVALS [10] = '{16'h0, 16'h1, 16'h2, 16'h3, 16'h7,
        16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFF9, 16'h1234};

    initial begin
        logic [7:0]  s;
        logic [31:0] v;
        logic [15:0] h;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every offset.
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), s);
            check("R1 reset value", {24'h0, s}, 32'h0);
        end

        // R10: operand read-back.
        wr32(A_DVD, 32'hA1B2C3D4);
        wr(A_MLT, 8'h11); wr(A_MLT + 4'd1, 8'h22);
        wr(A_DVS, 8'h33); wr(A_DVS + 4'd1, 8'h44);
        rd32(A_DVD, v); check("R10 dividend read-back", v, 32'hA1B2C3D4);
        rd16(A_MLT, h); check("R10 multiplier read-back", {16'h0, h}, 32'h2211);
        rd16(A_DVS, h); check("R10 divisor read-back", {16'h0, h}, 32'h4433);

        // R8: control write wipes operands, cancels the divide, keeps the flag.
        wr(A_CTRL, 8'h00);
        repeat (40) @(negedge clk);
        rd32(A_DVD, v); check("R8 dividend wiped", v, 32'h0);
        rd16(A_DVS, h); check("R8 divisor wiped", {16'h0, h}, 32'h0);
        rd(A_STAT, s); check("R8 cancelled divide never completes", {24'h0, s}, 32'h0);

        // R11: writes to result, remainder and status are ignored.
        wr(A_RES, 8'hFF); wr(A_RES + 4'd3, 8'hFF); wr(A_REM, 8'hFF); wr(A_STAT, 8'hFF);
        rd32(A_RES, v); check("R11 result unwritable", v, 32'h0);
        rd16(A_REM, h); check("R11 remainder unwritable", {16'h0, h}, 32'h0);
        rd(A_STAT, s); check("R11 status unwritable", {24'h0, s}, 32'h0);

        // R2/R3: multiply sweeps in both modes.
        for (int m = 0; m < 2; m++) begin
            wr(A_CTRL, 8'(m));
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    do_mul(MVALS[i], MVALS[j], m[0]);
        end

        // R4/R5/R6: divide sweeps in both modes.
        for (int m = 0; m < 2; m++) begin
            wr(A_CTRL, 8'(m));
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 10; j++) begin
                    do_div(NVALS[i], DVALS[j], m[0]);
                    rd(A_STAT, s);
                end
        end

        // R9: status read in the completing cycle.
        wr(A_CTRL, 8'h00);
        wr32(A_DVD, 32'd1000);
        wr(A_DVS, 8'd7); wr(A_DVS + 4'd1, 8'd0);
        repeat (31) @(negedge clk);
        rd(A_STAT, s); check("R9 read in completing cycle", {24'h0, s}, 32'h0);
        rd(A_STAT, s); check("R9 flag survives concurrent read", {24'h0, s}, 32'h80);
        rd(A_STAT, s); check("R7 second read clear", {24'h0, s}, 32'h0);
        rd32(A_RES, v); check("R9 quotient", v, 32'd142);
        rd16(A_REM, h); check("R9 remainder", {16'h0, h}, 32'd6);

        // R4: a divide start clears a pending multiply flag.
        wr(A_DVD, 8'd3); wr(A_MLT, 8'd5); wr(A_MLT + 4'd1, 8'd0);
        wr(A_DVS, 8'd2); wr(A_DVS + 4'd1, 8'd0);
        rd(A_STAT, s); check("R4 start clears flag", {24'h0, s}, 32'h0);
        repeat (31) @(negedge clk);
        rd(A_STAT, s); check("R4 flag after divide", {24'h0, s}, 32'h80);

        // R8: control write after a multiply wipes results but leaves the flag.
        wr(A_DVD, 8'd3); wr(A_MLT, 8'd5); wr(A_MLT + 4'd1, 8'd0);
        wr(A_CTRL, 8'hA5);
        rd32(A_RES, v); check("R8 result wiped", v, 32'h0);
        rd16(A_MLT, h); check("R8 multiplier wiped", {16'h0, h}, 32'h0);
        rd(A_CTRL, s); check("R8 control read-back", {24'h0, s}, 32'hA5);
        rd(A_STAT, s); check("R8 flag untouched", {24'h0, s}, 32'h80);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule